// File: doc/BRIEF.md
# PCI Type-0 Configuration Space Register File

This block holds the 256-byte configuration image of one PCI function with a type-0 header. A host-side agent, not part of this block, reaches it through a single request port. Each request is a byte, word or dword access at a byte offset. Reads return their data one cycle later. Writes commit at the clock edge that accepts them.

Each written byte passes through three filters:
- Identity and base-address bytes are protected against plain writes.
- The two status bytes clear wherever a 1 is written.
- Full-dword writes to an implemented base address register (BAR) or to the expansion ROM register are masked to the size of the region.

From the stored image the block derives, for the six BARs and the ROM, an enable flag and an aligned base address. These come from the command register's space-enable bits and, for the ROM, from its own enable bit. An address decoder elsewhere uses them to route memory and I/O cycles.

Parameters set the identity fields, the interrupt pin, the header type byte (0x00 or 0x80), the size and type bits of every BAR, the ROM size, and whether a single capability structure sits at 0x40.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset, the image holds the following, and every other byte is zero:
  - the vendor ID (LE) at 0x00, the device ID at 0x02, the revision at 0x08 and the 24-bit class code (LE) at 0x09;
  - the header type at 0x0E and the interrupt pin at 0x3D;
  - the type nibble in byte 0 of each implemented BAR.
  When a capability is present, the image also holds status bit 4 (byte 0x06), 0x40 in the capability pointer at 0x34, the capability ID at 0x40 and 0x00 at 0x41. No region is enabled after reset.
- R2: No write changes bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 or 0x3D. The one exception is the masked dword write of R5 and R6.
- R3: Every other byte except 0x06 and 0x07 takes the written data. Lane k of req_wdata (bits 8k+7:8k) goes to offset base+k. Size code 0 writes one lane, code 1 two lanes and code 2 four lanes.
- R4: A write covering 0x06 or 0x07 clears each status bit whose data bit is 1 and leaves the others. Status bits never go from 0 to 1.
- R5: A dword write to 0x10+4n for an implemented BAR n stores (data AND NOT(size-1)) OR type. For a BAR of size 0 the bytes stay zero.
- R6: A dword write to 0x30 for an implemented ROM stores data AND (NOT(size-1) OR 1).
- R7: Command bit 0 enables a region whose type bit 0 is 1 (I/O). Command bit 1 enables a memory-type region. The ROM needs command bit 1 and bit 0 of its register. A region of size 0 is never enabled.
- R8: region_base for region r (bits 32r+31:32r, r=6 is the ROM) is the register value with its low size-1 bits cleared while enabled, and zero while disabled. region_en and region_base reflect a write from the cycle right after its accepting edge.
- R9: A read request gives rsp_valid=1 and rsp_rdata one cycle later, little-endian and zero-extended. rsp_valid is 0 in every cycle that does not follow a read request.
- R10: A word access at 0xFF reads only byte 0xFF (upper bits zero) and writes only byte 0xFF.
- R11: Dword reads and writes ignore req_addr[1:0].
- R12: Size code 3 writes nothing, and a read with that code returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data, lane k at bits 8k+7:8k |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| region_en | output | 7 | Per-region enable, bit 6 is the ROM |
| region_base | output | 224 | Per-region base, 32 bits each |

## Verification
Directed accesses first separate the four write behaviours from one another:
- all-ones dwords over protected identity bytes;
- the same pattern into BARs of every kind: memory, I/O, unimplemented and ROM;
- zero and one patterns into the status bytes.

Command values 0, 1 and 2, together with setting and clearing the ROM enable bit, show which region depends on which enable source. Word accesses at 0xFF, dword accesses at unaligned offsets and size code 3 probe the edge handling.

A long random stream then mixes all sizes, with offsets biased toward the header. It compares every read and every region output after each write against a byte-level model, so that the interactions between lane splitting, protection and BAR masking are all exercised.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam int NUM_BYTES   = 256;
    localparam int NUM_BARS    = 6;
    localparam int NUM_REGIONS = NUM_BARS + 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_NONE  = 2'd3
    } acc_size_e;

    typedef logic [NUM_BYTES-1:0][7:0] cfg_image_t;

    localparam logic [7:0] OFS_CMD     = 8'h04;
    localparam logic [7:0] OFS_STAT_LO = 8'h06;
    localparam logic [7:0] OFS_STAT_HI = 8'h07;
    localparam logic [7:0] OFS_BAR0    = 8'h10;
    localparam logic [7:0] OFS_BARLAST = 8'h24;
    localparam logic [7:0] OFS_ROM     = 8'h30;
    localparam logic [7:0] OFS_CAPPTR  = 8'h34;
    localparam logic [7:0] OFS_INTPIN  = 8'h3D;
    localparam logic [7:0] OFS_CAP0    = 8'h40;

    localparam logic [NUM_BARS-1:0][31:0] DEF_BAR_SIZE =
        {32'h0, 32'h10, 32'h0, 32'h100, 32'h20, 32'h1000};
    localparam logic [NUM_BARS-1:0][3:0]  DEF_BAR_TYPE =
        {4'h0, 4'h1, 4'h0, 4'h8, 4'h1, 4'h0};
    localparam logic [31:0]               DEF_ROM_SIZE = 32'h800;

    // Bytes protected from plain writes in a type-0 header.
    function automatic logic byte_is_ro(input logic [7:0] a);
        return (a <= 8'h03)
            || (a >= 8'h08 && a <= 8'h0B)
            || (a == 8'h0E)
            || (a >= 8'h10 && a <= 8'h27)
            || (a >= 8'h30 && a <= 8'h33)
            || (a == OFS_INTPIN);
    endfunction

    function automatic logic byte_is_status(input logic [7:0] a);
        return (a == OFS_STAT_LO) || (a == OFS_STAT_HI);
    endfunction

    function automatic logic [7:0] access_base(input logic [1:0] sz, input logic [7:0] a);
        return (sz == SZ_DWORD) ? {a[7:2], 2'b00} : a;
    endfunction

endpackage

// File: rtl/cfgspace_write_engine.sv
module cfgspace_write_engine
    import cfgspace_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = DEF_BAR_SIZE,
    parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE = DEF_BAR_TYPE,
    parameter logic [31:0]               ROM_SIZE = DEF_ROM_SIZE
) (
    input  cfg_image_t  cfg_q,
    input  logic        wr_en,
    input  logic [1:0]  wr_size,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    output cfg_image_t  cfg_nx
);

    logic [7:0]  base;
    logic [2:0]  n_lanes;
    logic        in_bar_win;
    logic [31:0] sel_size;
    logic [3:0]  sel_type;
    logic        bar_hit;
    logic        rom_hit;
    logic [31:0] masked_val;
    logic [8:0]  lane_addr [4];

    always_comb begin
        base = access_base(wr_size, wr_addr);
        case (wr_size)
            SZ_BYTE:  n_lanes = 3'd1;
            SZ_WORD:  n_lanes = 3'd2;
            SZ_DWORD: n_lanes = 3'd4;
            default:  n_lanes = 3'd0;
        endcase

        in_bar_win = (wr_size == SZ_DWORD) && (base >= OFS_BAR0) && (base <= OFS_BARLAST);
        sel_size   = 32'd0;
        sel_type   = 4'd0;
        for (int n = 0; n < NUM_BARS; n++) begin
            if (in_bar_win && base == 8'(int'(OFS_BAR0) + 4 * n)) begin
                sel_size = BAR_SIZE[n];
                sel_type = BAR_TYPE[n];
            end
        end
        bar_hit = in_bar_win && (sel_size != 32'd0);
        rom_hit = (wr_size == SZ_DWORD) && (base == OFS_ROM) && (ROM_SIZE != 32'd0);

        if (bar_hit) begin
            masked_val = (wr_data & ~(sel_size - 32'd1)) | {28'd0, sel_type};
        end else begin
            masked_val = wr_data & (~(ROM_SIZE - 32'd1) | 32'd1);
        end

        for (int k = 0; k < 4; k++) begin
            lane_addr[k] = {1'b0, base} + 9'(k);
        end

        cfg_nx = cfg_q;
        if (wr_en) begin
            if (bar_hit || rom_hit) begin
                for (int k = 0; k < 4; k++) begin
                    cfg_nx[lane_addr[k][7:0]] = masked_val[8*k +: 8];
                end
            end else begin
                for (int k = 0; k < 4; k++) begin
                    if ((3'(k) < n_lanes) && !lane_addr[k][8]) begin
                        if (byte_is_status(lane_addr[k][7:0])) begin
                            cfg_nx[lane_addr[k][7:0]] = cfg_q[lane_addr[k][7:0]] & ~wr_data[8*k +: 8];
                        end else if (!byte_is_ro(lane_addr[k][7:0])) begin
                            cfg_nx[lane_addr[k][7:0]] = wr_data[8*k +: 8];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfgspace_read_mux.sv
module cfgspace_read_mux
    import cfgspace_pkg::*;
(
    input  cfg_image_t  cfg_q,
    input  logic [1:0]  rd_size,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data
);

    logic [7:0] dw_base;

    always_comb begin
        dw_base = access_base(SZ_DWORD, rd_addr);
        case (rd_size)
            SZ_BYTE: rd_data = {24'd0, cfg_q[rd_addr]};
            SZ_WORD: begin
                if (rd_addr == 8'hFF) begin
                    rd_data = {24'd0, cfg_q[8'hFF]};
                end else begin
                    rd_data = {16'd0, cfg_q[rd_addr + 8'd1], cfg_q[rd_addr]};
                end
            end
            SZ_DWORD: rd_data = {cfg_q[dw_base | 8'd3], cfg_q[dw_base | 8'd2],
                                 cfg_q[dw_base | 8'd1], cfg_q[dw_base]};
            default:  rd_data = 32'd0;
        endcase
    end

endmodule

// File: rtl/cfgspace_region_decode.sv
module cfgspace_region_decode #(
    parameter logic [31:0] REGION_SIZE = 32'h0,
    parameter bit          IS_IO       = 1'b0,
    parameter bit          IS_ROM      = 1'b0
) (
    input  logic [31:0] bar_value,
    input  logic        io_space_on,
    input  logic        mem_space_on,
    output logic        enabled,
    output logic [31:0] base
);

    localparam bit          IMPLEMENTED = (REGION_SIZE != 32'h0);
    localparam logic [31:0] ADDR_MASK   = ~(REGION_SIZE - 32'd1);

    logic space_ok;

    always_comb begin
        if (IS_IO) begin
            space_ok = io_space_on;
        end else begin
            space_ok = mem_space_on && (!IS_ROM || bar_value[0]);
        end
        enabled = IMPLEMENTED && space_ok;
        base    = enabled ? (bar_value & ADDR_MASK) : 32'd0;
    end

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
    import cfgspace_pkg::*;
#(
    parameter logic [15:0]               VENDOR_ID   = 16'hABCD,
    parameter logic [15:0]               DEVICE_ID   = 16'h1234,
    parameter logic [7:0]                REVISION    = 8'h03,
    parameter logic [23:0]               CLASS_CODE  = 24'h020000,
    parameter logic [7:0]                HDR_TYPE    = 8'h00,
    parameter logic [7:0]                INT_PIN     = 8'h01,
    parameter bit                        CAP_PRESENT = 1'b1,
    parameter logic [7:0]                CAP_ID      = 8'h05,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE    = DEF_BAR_SIZE,
    parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE    = DEF_BAR_TYPE,
    parameter logic [31:0]               ROM_SIZE    = DEF_ROM_SIZE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [7:0]                req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    output logic [NUM_REGIONS-1:0]    region_en,
    output logic [NUM_REGIONS*32-1:0] region_base
);

    typedef struct packed {
        cfg_image_t                        cfg;
        logic                              rsp_valid;
        logic [31:0]                       rsp_rdata;
        logic [NUM_REGIONS-1:0]            en;
        logic [NUM_REGIONS-1:0][31:0]      base;
    } state_t;

    function automatic cfg_image_t build_reset_image();
        cfg_image_t img;
        img = '0;
        img[8'h00] = VENDOR_ID[7:0];
        img[8'h01] = VENDOR_ID[15:8];
        img[8'h02] = DEVICE_ID[7:0];
        img[8'h03] = DEVICE_ID[15:8];
        img[8'h08] = REVISION;
        img[8'h09] = CLASS_CODE[7:0];
        img[8'h0A] = CLASS_CODE[15:8];
        img[8'h0B] = CLASS_CODE[23:16];
        img[8'h0E] = HDR_TYPE;
        img[OFS_INTPIN] = INT_PIN;
        for (int n = 0; n < NUM_BARS; n++) begin
            if (BAR_SIZE[n] != 32'd0) begin
                img[int'(OFS_BAR0) + 4 * n] = {4'd0, BAR_TYPE[n]};
            end
        end
        if (CAP_PRESENT) begin
            img[OFS_STAT_LO] = 8'h10;
            img[OFS_CAPPTR]  = OFS_CAP0;
            img[OFS_CAP0]    = CAP_ID;
            img[OFS_CAP0 + 8'd1] = 8'h00;
        end
        return img;
    endfunction

    localparam cfg_image_t RESET_IMAGE = build_reset_image();
    localparam state_t RESET_STATE = '{
        cfg:       RESET_IMAGE,
        rsp_valid: 1'b0,
        rsp_rdata: 32'd0,
        en:        '0,
        base:      '0
    };

    state_t state_d, state_q;

    cfg_image_t                   cfg_nx;
    logic [31:0]                  rd_word;
    logic [NUM_REGIONS-1:0]       dec_en;
    logic [NUM_REGIONS-1:0][31:0] dec_base;
    logic                         is_read;

    // Views of the stored image for the bound checker.
    logic [7:0]  cmd_q;
    logic [15:0] status_q;
    logic [31:0] ident_q;

    assign is_read = req_valid && !req_write;

    cfgspace_write_engine #(
        .BAR_SIZE (BAR_SIZE),
        .BAR_TYPE (BAR_TYPE),
        .ROM_SIZE (ROM_SIZE)
    ) u_write_engine (
        .cfg_q   (state_q.cfg),
        .wr_en   (req_valid && req_write),
        .wr_size (req_size),
        .wr_addr (req_addr),
        .wr_data (req_wdata),
        .cfg_nx  (cfg_nx)
    );

    cfgspace_read_mux u_read_mux (
        .cfg_q   (state_q.cfg),
        .rd_size (req_size),
        .rd_addr (req_addr),
        .rd_data (rd_word)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        if (r == NUM_BARS) begin : g_rom
            cfgspace_region_decode #(
                .REGION_SIZE (ROM_SIZE),
                .IS_IO       (1'b0),
                .IS_ROM      (1'b1)
            ) u_decode (
                .bar_value    (cfg_nx[int'(OFS_ROM) +: 4]),
                .io_space_on  (cfg_nx[OFS_CMD][0]),
                .mem_space_on (cfg_nx[OFS_CMD][1]),
                .enabled      (dec_en[r]),
                .base         (dec_base[r])
            );
        end else begin : g_bar
            cfgspace_region_decode #(
                .REGION_SIZE (BAR_SIZE[r]),
                .IS_IO       (BAR_TYPE[r][0]),
                .IS_ROM      (1'b0)
            ) u_decode (
                .bar_value    (cfg_nx[int'(OFS_BAR0) + 4 * r +: 4]),
                .io_space_on  (cfg_nx[OFS_CMD][0]),
                .mem_space_on (cfg_nx[OFS_CMD][1]),
                .enabled      (dec_en[r]),
                .base         (dec_base[r])
            );
        end
    end

    always_comb begin
        state_d           = state_q;
        state_d.cfg       = cfg_nx;
        state_d.rsp_valid = is_read;
        state_d.rsp_rdata = is_read ? rd_word : 32'd0;
        state_d.en        = dec_en;
        state_d.base      = dec_base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid   = state_q.rsp_valid;
    assign rsp_rdata   = state_q.rsp_rdata;
    assign region_en   = state_q.en;
    assign region_base = state_q.base;

    assign cmd_q    = state_q.cfg[OFS_CMD];
    assign status_q = {state_q.cfg[OFS_STAT_HI], state_q.cfg[OFS_STAT_LO]};
    assign ident_q  = {state_q.cfg[8'h03], state_q.cfg[8'h02], state_q.cfg[8'h01], state_q.cfg[8'h00]};

endmodule

// File: rtl/cfgspace_regfile_checker.sv
module cfgspace_regfile_checker
    import cfgspace_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = DEF_BAR_SIZE,
    parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE = DEF_BAR_TYPE,
    parameter logic [31:0]               ROM_SIZE = DEF_ROM_SIZE
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic                      rsp_valid,
    input logic [NUM_REGIONS-1:0]    region_en,
    input logic [NUM_REGIONS*32-1:0] region_base,
    input logic [7:0]                cmd_q,
    input logic [15:0]               status_q,
    input logic [31:0]               ident_q
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R9
    AST_STATUS_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q)) == 16'd0)); // R4
    AST_IDENT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ident_q)); // R2

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
        localparam logic [31:0] RSZ   = (r == NUM_BARS) ? ROM_SIZE : BAR_SIZE[(r == NUM_BARS) ? 0 : r];
        localparam bit          IO_T  = (r == NUM_BARS) ? 1'b0 : BAR_TYPE[(r == NUM_BARS) ? 0 : r][0];

        AST_BASE_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !region_en[r] |-> (region_base[32*r +: 32] == 32'd0)); // R8
        AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            region_en[r] |-> ((region_base[32*r +: 32] & (RSZ - 32'd1)) == 32'd0)); // R8
        AST_EN_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
            region_en[r] |-> (IO_T ? cmd_q[0] : cmd_q[1])); // R7
        AST_UNIMPL_NEVER_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (RSZ == 32'd0) |-> !region_en[r]); // R7
    end

endmodule

bind cfgspace_regfile cfgspace_regfile_checker #(
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE),
    .ROM_SIZE (ROM_SIZE)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .region_en   (region_en),
    .region_base (region_base),
    .cmd_q       (cmd_q),
    .status_q    (status_q),
    .ident_q     (ident_q)
);

// File: tb/cfgspace_regfile_bench.sv
module cfgspace_regfile_bench;

    localparam logic [15:0]       T_VEN   = 16'hBEEF;
    localparam logic [15:0]       T_DEV   = 16'h0C51;
    localparam logic [7:0]        T_REV   = 8'h07;
    localparam logic [23:0]       T_CLASS = 24'h058000;
    localparam logic [7:0]        T_HDR   = 8'h80;
    localparam logic [7:0]        T_PIN   = 8'h02;
    localparam logic [7:0]        T_CAPID = 8'h09;
    localparam logic [5:0][31:0]  T_BSZ   = {32'h0, 32'h10, 32'h0, 32'h100, 32'h20, 32'h1000};
    localparam logic [5:0][3:0]   T_BTY   = {4'h0, 4'h1, 4'h0, 4'h8, 4'h1, 4'h0};
    localparam logic [31:0]       T_ROM   = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [6:0]  region_en;
    logic [223:0] region_base;

    int checks = 0;
    int failures = 0;
    logic [7:0] m [256];

    always #4 clk = ~clk;

    cfgspace_regfile #(
        .VENDOR_ID (T_VEN), .DEVICE_ID (T_DEV), .REVISION (T_REV),
        .CLASS_CODE (T_CLASS), .HDR_TYPE (T_HDR), .INT_PIN (T_PIN),
        .CAP_PRESENT (1'b1), .CAP_ID (T_CAPID),
        .BAR_SIZE (T_BSZ), .BAR_TYPE (T_BTY), .ROM_SIZE (T_ROM)
    ) u_cfgspace_regfile (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .region_en (region_en), .region_base (region_base)
    );

    // ---------------- model from the requirements ----------------
    function automatic logic prot(input logic [7:0] a);
        return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == 8'h0E ||
               (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33) || a == 8'h3D;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        m[0] = T_VEN[7:0];  m[1] = T_VEN[15:8];
        m[2] = T_DEV[7:0];  m[3] = T_DEV[15:8];
        m[8] = T_REV; m[9] = T_CLASS[7:0]; m[10] = T_CLASS[15:8]; m[11] = T_CLASS[23:16];
        m[14] = T_HDR; m[61] = T_PIN;
        for (int n = 0; n < 6; n++) if (T_BSZ[n] != 0) m[16 + 4*n] = {4'd0, T_BTY[n]};
        m[6] = 8'h10; m[52] = 8'h40; m[64] = T_CAPID; m[65] = 8'h00;
    endfunction

    function automatic logic [31:0] mdw(input int b);
        return {m[b+3], m[b+2], m[b+1], m[b]};
    endfunction

    function automatic void put_dw(input int b, input logic [31:0] v);
        for (int k = 0; k < 4; k++) m[b+k] = v[8*k +: 8];
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        int b;
        int nb;
        if (sz == 2'd3) return;
        b = (sz == 2'd2) ? int'({a[7:2], 2'b00}) : int'(a);
        if (sz == 2'd2 && b >= 16 && b <= 36 && T_BSZ[(b-16)/4] != 0) begin
            put_dw(b, (d & ~(T_BSZ[(b-16)/4] - 1)) | {28'd0, T_BTY[(b-16)/4]});
            return;
        end
        if (sz == 2'd2 && b == 48) begin
            put_dw(b, d & (~(T_ROM - 1) | 32'd1));
            return;
        end
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k < nb; k++) begin
            if (b + k <= 255) begin
                if (b + k == 6 || b + k == 7) m[b+k] = m[b+k] & ~d[8*k +: 8];
                else if (!prot(8'(b + k))) m[b+k] = d[8*k +: 8];
            end
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] sz);
        case (sz)
            2'd0: return {24'd0, m[a]};
            2'd1: return (a == 8'hFF) ? {24'd0, m[255]} : {16'd0, m[int'(a)+1], m[a]};
            2'd2: return mdw(int'({a[7:2], 2'b00}));
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic model_en(input int r);
        logic [31:0] sz;
        logic [31:0] v;
        sz = (r == 6) ? T_ROM : T_BSZ[r];
        v  = (r == 6) ? mdw(48) : mdw(16 + 4*r);
        if (sz == 0) return 1'b0;
        if (r != 6 && T_BTY[r][0]) return m[4][0];
        if (r == 6) return m[4][1] && v[0];
        return m[4][1];
    endfunction

    function automatic logic [31:0] model_base(input int r);
        logic [31:0] sz;
        logic [31:0] v;
        sz = (r == 6) ? T_ROM : T_BSZ[r];
        v  = (r == 6) ? mdw(48) : mdw(16 + 4*r);
        return model_en(r) ? (v & ~(sz - 1)) : 32'd0;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input logic [1:0] sz);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk(tag, rsp_rdata, model_read(a, sz));
    endtask

    task automatic chk_regions(input string tag);
        for (int r = 0; r < 7; r++) begin
            chk({tag, " R7 en"}, {31'd0, region_en[r]}, {31'd0, model_en(r)});
            chk({tag, " R8 base"}, region_base[32*r +: 32], model_base(r));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 region_en after reset", {25'd0, region_en}, 32'd0);
        chk("R1 ident dword", model_read(8'h00, 2'd2), {T_DEV, T_VEN});
        do_read("R1 ident", 8'h00, 2'd2);
        do_read("R1 class/rev", 8'h08, 2'd2);
        do_read("R1 status cap bit", 8'h06, 2'd1);
        chk("R1 status value", model_read(8'h06, 2'd1), 32'h0010);
        do_read("R1 cap pointer", 8'h34, 2'd0);
        do_read("R1 cap header", 8'h40, 2'd1);
        do_read("R1 header/pin", 8'h3C, 2'd2);
        do_read("R1 bar1 type", 8'h14, 2'd2);

        // R2 protected bytes
        do_write(8'h00, 2'd2, 32'hFFFF_FFFF);
        do_read("R2 ident after write", 8'h00, 2'd2);
        do_write(8'h3D, 2'd0, 8'h77);
        do_read("R2 int pin after write", 8'h3C, 2'd2);
        do_write(8'h12, 2'd1, 32'h0000_5555);
        do_read("R2 bar0 after word write", 8'h10, 2'd2);

        // R3 lanes
        do_write(8'h2C, 2'd2, 32'h1122_3344);
        do_read("R3 byte lane", 8'h2D, 2'd0);
        do_read("R3 word lane", 8'h2E, 2'd1);

        // R4 W1C status
        do_write(8'h06, 2'd0, 8'h00);
        do_read("R4 zero write keeps", 8'h06, 2'd1);
        do_write(8'h06, 2'd1, 32'h0000_FFEF);
        do_read("R4 unrelated ones", 8'h06, 2'd1);
        do_write(8'h04, 2'd2, 32'h0010_0000);
        do_read("R4 cleared via dword", 8'h04, 2'd2);

        // R5/R6 masking
        do_write(8'h10, 2'd2, 32'hFFFF_FFFF);
        do_read("R5 mem bar mask", 8'h10, 2'd2);
        do_write(8'h14, 2'd2, 32'hFFFF_FFFF);
        do_read("R5 io bar mask", 8'h14, 2'd2);
        do_write(8'h1C, 2'd2, 32'hFFFF_FFFF);
        do_read("R5 unimplemented bar", 8'h1C, 2'd2);
        do_write(8'h30, 2'd2, 32'hFFFF_FFFF);
        do_read("R6 rom mask", 8'h30, 2'd2);
        chk("R6 rom value", model_read(8'h30, 2'd2), 32'hFFFF_F801);

        // R7/R8 enable sources
        do_write(8'h10, 2'd2, 32'h8000_2345);
        do_write(8'h18, 2'd2, 32'hC000_0ABC);
        do_write(8'h20, 2'd2, 32'h0000_C0DE);
        do_write(8'h04, 2'd1, 32'h0000_0000);
        chk_regions("cmd=0");
        do_write(8'h04, 2'd0, 8'h01);
        chk_regions("cmd=io");
        do_write(8'h04, 2'd0, 8'h02);
        chk_regions("cmd=mem");
        chk("R8 bar0 base", region_base[31:0], 32'h8000_2000);
        do_write(8'h30, 2'd2, 32'h0001_0000);
        chk_regions("rom off");
        chk("R7 rom disabled", {31'd0, region_en[6]}, 32'd0);
        do_write(8'h04, 2'd0, 8'h03);
        chk_regions("cmd=both");

        // R10 word at 0xFF
        do_write(8'hFF, 2'd1, 32'h0000_ABCD);
        do_read("R10 word read at FF", 8'hFF, 2'd1);
        chk("R10 value", model_read(8'hFF, 2'd1), 32'h0000_00CD);

        // R11 unaligned dword
        do_read("R11 unaligned dword read", 8'h2D, 2'd2);
        do_write(8'h13, 2'd2, 32'h4000_0000);
        do_read("R11 unaligned dword write", 8'h10, 2'd2);
        chk_regions("R11 regions");

        // R12 size code 3
        do_write(8'h2C, 2'd3, 32'hDEAD_BEEF);
        do_read("R12 no write", 8'h2C, 2'd2);
        do_read("R12 read returns zero", 8'h2C, 2'd3);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [1:0]  sz;
            logic [31:0] d;
            a  = ($urandom % 3 != 0) ? 8'($urandom % 72) : 8'($urandom);
            sz = 2'($urandom % 4);
            d  = $urandom;
            if ($urandom % 2 == 0) begin
                do_write(a, sz, d);
                chk_regions("random R8 after write");
            end else begin
                do_read("random R3 read", a, sz);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule